// File: doc/BRIEF.md
# Multicast Hash Address Filter

This block decides whether a received frame addressed to a multicast group is accepted. It watches the receive byte stream and runs a 32-bit Ethernet CRC over the six destination address bytes as they arrive. After the last address byte it turns the CRC into an 8-bit hash index and looks up one bit of a 256-entry group table. The result is a one-cycle decision strobe with an accept flag.

The table is held as eight 32-bit words. A small configuration port can overwrite a whole word or set or clear one table entry chosen by its 8-bit hash index, so software can add or drop a group without a read-modify-write. A combinational read port returns any word. Frames whose destination is an individual (unicast) address are never accepted by this filter.

Top module: `mhf_filter`

## Requirements
- R1: The hash index is formed from a CRC register preset to all ones at a start-of-frame byte. Each byte is shifted in least significant bit first with the reflected polynomial 0xEDB88320 and no final inversion. Index bit 7 is CRC register bit 0, index bit 6 is bit 1, and so on down to index bit 0 = bit 7, which equals the top 8 bits of the MSB-first CRC.
- R2: Index bits [7:5] select table word 0..7 and index bits [4:0] value b select bit (31 - b) of that word, so entry 0 is word 0 bit 31 and entry 255 is word 7 bit 0.
- R3: `dec_valid` is high for exactly one cycle, the cycle after the clock edge that takes the sixth address byte; `dec_accept` is high only together with `dec_valid`, and only when the selected table bit is 1.
- R4: When bit 0 of the first destination byte is 0 (individual address), `dec_accept` stays 0 whatever the table holds.
- R5: Only cycles with `rx_valid` high advance the address byte count; bytes after the sixth are ignored until the next `rx_sof`, so there is at most one decision per frame.
- R6: `cfg_op` = 2'b01 replaces word `cfg_addr` with `cfg_wdata`; `rd_data` always shows word `rd_addr`.
- R7: `cfg_op` = 2'b10 sets and `cfg_op` = 2'b11 clears the single entry `cfg_index`, leaving every other table bit unchanged; 2'b00 does nothing.
- R8: After reset all eight words read 0 and no decision strobe is produced until a frame arrives.
- R9: A configuration operation in the same cycle as the sixth address byte does not affect that frame's decision; it applies from the next lookup.
- R10: A byte with `rx_sof` high always starts a new address, even if the previous one was incomplete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | Receive byte valid |
| rx_sof | input | 1 | Marks the first byte of a frame |
| rx_data | input | 8 | Receive byte, destination address first |
| cfg_op | input | 2 | 00 none, 01 write word, 10 set entry, 11 clear entry |
| cfg_addr | input | 3 | Word select for a word write |
| cfg_wdata | input | 32 | Data for a word write |
| cfg_index | input | 8 | Hash index for set or clear |
| rd_addr | input | 3 | Word select for reads |
| rd_data | output | 32 | Table word contents |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted by the group table |

## Verification
The hardest situation to reach is a table change landing in the exact cycle the sixth address byte is consumed, since the lookup and the update then share one clock edge. The stimulus drives a set or clear of the very index the frame hashes to together with its last byte, checks that the decision reflects the old table, and then repeats the frame to see the new one. Single-entry tables programmed from an independently computed index show that a wrong CRC bit or bit order would miss.

// File: rtl/mhf_pkg.sv
// Shared types and the CRC byte step for the multicast hash filter.
// Assumes bytes enter least significant bit first (reflected CRC).
package mhf_pkg;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } cfg_op_e;

    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET    = 32'hFFFF_FFFF;

    // Advance a reflected CRC register by one byte, LSB first.
    function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                  input logic [7:0]  d);
        logic [31:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ d[i];
            c  = c >> 1;
            if (fb) c = c ^ CRC_POLY_REFL;
        end
        return c;
    endfunction

endpackage

// File: rtl/mhf_crc_acc.sv
// Address CRC accumulator.
// Counts destination address bytes, keeps a running CRC and the group flag
// from the first byte. Flags the cycle in which the last address byte is
// taken and presents the CRC including that byte. Assumes ADDR_BYTES >= 2.
module mhf_crc_acc
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    localparam int CNT_W = $clog2(ADDR_BYTES + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rx_valid,
    input  logic        rx_sof,
    input  logic [7:0]  rx_data,
    output logic [31:0] crc_next,
    output logic        last_byte,
    output logic        grp_cur,
    output logic        grp_q
);

    logic [CNT_W-1:0] cnt_q;
    logic [31:0]      crc_q;
    logic             take;

    // Decide whether this byte belongs to the address and what the CRC becomes.
    always_comb begin
        take      = rx_valid && (rx_sof || (cnt_q < CNT_W'(ADDR_BYTES)));
        crc_next  = crc_step_byte(rx_sof ? CRC_PRESET : crc_q, rx_data);
        grp_cur   = rx_sof ? rx_data[0] : grp_q;
        last_byte = take && !rx_sof && (cnt_q == CNT_W'(ADDR_BYTES - 1));
    end

    // Hold the running CRC, byte count and group flag between bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(ADDR_BYTES);
            crc_q <= CRC_PRESET;
            grp_q <= 1'b0;
        end else if (take) begin
            crc_q <= crc_next;
            grp_q <= grp_cur;
            cnt_q <= rx_sof ? CNT_W'(1) : cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/mhf_hash_table.sv
// Group hash table: TBL_WORDS words of WORD_W bits, MSB-first entry numbering.
// Supports whole-word write and single-entry set/clear; one lookup port and
// one read port, both combinational from the stored state.
// Assumes WORD_W is a power of two.
module mhf_hash_table
    import mhf_pkg::*;
#(
    parameter int TBL_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int SEL_W = $clog2(TBL_WORDS),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int IDX_W = SEL_W + BIT_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  cfg_op,
    input  logic [SEL_W-1:0]            cfg_addr,
    input  logic [WORD_W-1:0]           cfg_wdata,
    input  logic [IDX_W-1:0]            cfg_index,
    input  logic [SEL_W-1:0]            rd_addr,
    input  logic [IDX_W-1:0]            lk_index,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        lk_hit,
    output logic [TBL_WORDS*WORD_W-1:0] tbl_flat
);

    cfg_op_e           op;
    logic [SEL_W-1:0]  op_sel;
    logic [BIT_W-1:0]  op_bit;
    logic [WORD_W-1:0] words [TBL_WORDS];

    // Split the configuration index into word select and bit number.
    always_comb begin
        op     = cfg_op_e'(cfg_op);
        op_sel = cfg_index[IDX_W-1:BIT_W];
        op_bit = cfg_index[BIT_W-1:0];
    end

    for (genvar g = 0; g < TBL_WORDS; g++) begin : g_word
        // Update one table word from the configuration operation.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
            end else begin
                case (op)
                    OP_WRITE: if (cfg_addr == SEL_W'(g)) words[g] <= cfg_wdata;
                    OP_SET:   if (op_sel == SEL_W'(g)) words[g][~op_bit] <= 1'b1;
                    OP_CLEAR: if (op_sel == SEL_W'(g)) words[g][~op_bit] <= 1'b0;
                    default:  ;
                endcase
            end
        end
        assign tbl_flat[g*WORD_W +: WORD_W] = words[g];
    end

    logic [BIT_W-1:0] lk_bit;

    // Read a word and look up one entry (bit ~b is bit WORD_W-1-b).
    always_comb begin
        rd_data = words[rd_addr];
        lk_bit  = lk_index[BIT_W-1:0];
        lk_hit  = words[lk_index[IDX_W-1:BIT_W]][~lk_bit];
    end

endmodule

// File: rtl/mhf_filter.sv
// Multicast hash address filter top.
// Hashes the destination address of each frame, looks up the group table
// and emits a one-cycle decision. Lookup uses the table as it stood before
// the edge that takes the last address byte.
module mhf_filter
    import mhf_pkg::*;
#(
    parameter int ADDR_BYTES = 6,
    parameter int TBL_WORDS  = 8,
    parameter int WORD_W     = 32,
    localparam int SEL_W = $clog2(TBL_WORDS),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int IDX_W = SEL_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic [7:0]        rx_data,
    input  logic [1:0]        cfg_op,
    input  logic [SEL_W-1:0]  cfg_addr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic [IDX_W-1:0]  cfg_index,
    input  logic [SEL_W-1:0]  rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic              dec_valid,
    output logic              dec_accept
);

    logic [31:0]                 crc_next;
    logic                        last_byte;
    logic                        grp_cur;
    logic                        grp_q;
    logic [IDX_W-1:0]            hash_idx;
    logic                        lk_hit;
    logic [TBL_WORDS*WORD_W-1:0] tbl_flat;

    mhf_crc_acc #(.ADDR_BYTES(ADDR_BYTES)) u_crc (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_sof    (rx_sof),
        .rx_data   (rx_data),
        .crc_next  (crc_next),
        .last_byte (last_byte),
        .grp_cur   (grp_cur),
        .grp_q     (grp_q)
    );

    // Index = bit-reversed low CRC bits (top bits of the MSB-first CRC).
    for (genvar i = 0; i < IDX_W; i++) begin : g_rev
        assign hash_idx[IDX_W-1-i] = crc_next[i];
    end

    mhf_hash_table #(.TBL_WORDS(TBL_WORDS), .WORD_W(WORD_W)) u_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_op    (cfg_op),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_index (cfg_index),
        .rd_addr   (rd_addr),
        .lk_index  (hash_idx),
        .rd_data   (rd_data),
        .lk_hit    (lk_hit),
        .tbl_flat  (tbl_flat)
    );

    // Register the decision for the frame whose last address byte is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
        end else begin
            dec_valid  <= last_byte;
            dec_accept <= last_byte && grp_cur && lk_hit;
        end
    end

endmodule

// File: rtl/mhf_filter_chk.sv
// Property checker for the multicast hash filter, bound to the top.
// Observes the decision outputs, the stored group flag and the table bits.
module mhf_filter_chk #(
    parameter int TBL_WORDS = 8,
    parameter int WORD_W    = 32,
    localparam int SEL_W = $clog2(TBL_WORDS),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int IDX_W = SEL_W + BIT_W
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        dec_valid,
    input logic                        dec_accept,
    input logic                        grp_q,
    input logic [1:0]                  cfg_op,
    input logic [IDX_W-1:0]            cfg_index,
    input logic [TBL_WORDS*WORD_W-1:0] tbl_flat
);

    logic [IDX_W-1:0] flat_pos;

    // Flat table position of the entry named by cfg_index.
    always_comb flat_pos = {cfg_index[IDX_W-1:BIT_W], ~cfg_index[BIT_W-1:0]};

    AST_DEC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |=> !dec_valid);                                          // R3
    AST_ACCEPT_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> dec_valid);                                          // R3
    AST_UNICAST_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        dec_accept |-> grp_q);                                              // R4
    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (tbl_flat == '0));                                // R8
    AST_SET_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_op == 2'b10) |=> tbl_flat[$past(flat_pos)]);                   // R7
    AST_CLEAR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_op == 2'b11) |=> !tbl_flat[$past(flat_pos)]);                  // R7

endmodule

bind mhf_filter mhf_filter_chk #(.TBL_WORDS(TBL_WORDS), .WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .grp_q      (grp_q),
    .cfg_op     (cfg_op),
    .cfg_index  (cfg_index),
    .tbl_flat   (tbl_flat)
);

// File: tb/mhf_filter_tb.sv
// Self-checking bench for the multicast hash filter.
module mhf_filter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic [1:0]  cfg_op = 2'b00;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [7:0]  cfg_index = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        dec_valid;
    logic        dec_accept;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    mhf_filter u_dut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_data(rx_data), .cfg_op(cfg_op), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_index(cfg_index), .rd_addr(rd_addr),
        .rd_data(rd_data), .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    // Count decision strobes seen by the bench.
    always @(posedge clk) if (dec_valid) pulses <= pulses + 1;

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference hash: serial reflected CRC, then reverse and keep top byte.
    function automatic logic [7:0] ref_index(input logic [47:0] a);
        logic [31:0] c;
        logic [31:0] r;
        c = 32'hFFFF_FFFF;
        for (int k = 0; k < 6; k++) begin
            for (int j = 0; j < 8; j++) begin
                if (c[0] ^ a[47 - 8*k - 7 + j]) c = (c >> 1) ^ 32'hEDB8_8320;
                else                             c = c >> 1;
            end
        end
        for (int j = 0; j < 32; j++) r[31-j] = c[j];
        return r[31:24];
    endfunction

    task automatic cfg(input logic [1:0] op, input logic [2:0] adr,
                       input logic [31:0] wd, input logic [7:0] idx);
        @(negedge clk);
        cfg_op = op; cfg_addr = adr; cfg_wdata = wd; cfg_index = idx;
        @(negedge clk);
        cfg_op = 2'b00;
    endtask

    task automatic clear_table();
        for (int w = 0; w < 8; w++) cfg(2'b01, 3'(w), 32'h0, 8'h0);
    endtask

    // Send six address bytes; optional gap before byte 3, an op with byte 5,
    // and extra trailing bytes. Returns strobe/accept one cycle after byte 5
    // and the strobe one cycle later.
    task automatic send(input logic [47:0] a, input int gap,
                        input logic [1:0] op, input logic [7:0] idx, input int extra,
                        output logic dv, output logic da, output logic dv2);
        for (int b = 0; b < 6; b++) begin
            if (b == 3) repeat (gap) begin
                @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
            end
            @(negedge clk);
            rx_valid = 1'b1; rx_sof = (b == 0); rx_data = a[47 - 8*b -: 8];
            if (b == 5) begin cfg_op = op; cfg_index = idx; end
        end
        @(negedge clk);
        cfg_op = 2'b00;
        dv = dec_valid; da = dec_accept;
        rx_valid = (extra > 0); rx_sof = 1'b0; rx_data = 8'hA5;
        @(negedge clk);
        dv2 = dec_valid;
        for (int e = 1; e < extra; e++) @(negedge clk);
        rx_valid = 1'b0;
        @(negedge clk);
    endtask

    localparam int NV = 8;
    // {mode, address}: mode 0 = empty table, 1 = own entry, 2 = neighbour entry
    localparam logic [49:0] VEC [NV] = '{
        {2'd1, 48'h01005E000001}, {2'd1, 48'h3333FF123456},
        {2'd2, 48'h0180C2000000}, {2'd1, 48'h001122334455},
        {2'd1, 48'hFFFFFFFFFFFF}, {2'd0, 48'h01005E7FFFFA},
        {2'd1, 48'h0A0000000000}, {2'd1, 48'h091500000001}
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic dv, da, dv2;
        logic [47:0] a;
        logic [7:0]  ix;
        int          p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R8: empty table and quiet outputs after reset
        for (int w = 0; w < 8; w++) begin
            rd_addr = 3'(w); #1;
            check(rd_data == 32'h0, "R8 reset word", rd_data, 32'h0);
        end
        check(dec_valid == 1'b0, "R8 no strobe", {31'h0, dec_valid}, 32'h0);

        // Vector walk: R1 index, R2 mapping, R3 timing, R4 unicast
        foreach (VEC[v]) begin
            a  = VEC[v][47:0];
            ix = ref_index(a);
            clear_table();
            if (VEC[v][49:48] == 2'd1) cfg(2'b10, 3'h0, 32'h0, ix);
            if (VEC[v][49:48] == 2'd2) cfg(2'b10, 3'h0, 32'h0, ix ^ 8'h01);
            send(a, 0, 2'b00, 8'h0, 0, dv, da, dv2);
            check(dv == 1'b1 && dv2 == 1'b0, "R3 single strobe", {30'h0, dv, dv2}, 32'h2);
            check(da == ((VEC[v][49:48] == 2'd1) && a[40]), "R1/R4 accept",
                  {31'h0, da}, {31'h0, (VEC[v][49:48] == 2'd1) && a[40]});
        end

        // R2 and R7: entry placement and single-bit set/clear
        clear_table();
        cfg(2'b10, 3'h0, 32'h0, 8'd0);
        rd_addr = 3'd0; #1;
        check(rd_data == 32'h8000_0000, "R2 entry 0 is word0 bit31", rd_data, 32'h8000_0000);
        cfg(2'b10, 3'h0, 32'h0, 8'd255);
        rd_addr = 3'd7; #1;
        check(rd_data == 32'h0000_0001, "R2 entry 255 is word7 bit0", rd_data, 32'h1);
        cfg(2'b10, 3'h0, 32'h0, 8'd37);
        rd_addr = 3'd1; #1;
        check(rd_data == 32'h0400_0000, "R2 entry 37", rd_data, 32'h0400_0000);
        cfg(2'b01, 3'd4, 32'hFFFF_FFFF, 8'h0);
        cfg(2'b11, 3'h0, 32'h0, 8'd132);
        rd_addr = 3'd4; #1;
        check(rd_data == 32'hF7FF_FFFF, "R7 clear one bit", rd_data, 32'hF7FF_FFFF);
        cfg(2'b00, 3'd4, 32'h0, 8'd133);
        #1;
        check(rd_data == 32'hF7FF_FFFF, "R7 op none", rd_data, 32'hF7FF_FFFF);

        // R6: word write and read back
        cfg(2'b01, 3'd5, 32'h1234_5678, 8'h0);
        rd_addr = 3'd5; #1;
        check(rd_data == 32'h1234_5678, "R6 word write", rd_data, 32'h1234_5678);
        rd_addr = 3'd6; #1;
        check(rd_data == 32'h0, "R6 other word untouched", rd_data, 32'h0);

        // R4: unicast with a full table
        for (int w = 0; w < 8; w++) cfg(2'b01, 3'(w), 32'hFFFF_FFFF, 8'h0);
        send(48'h020000ABCDEF, 0, 2'b00, 8'h0, 0, dv, da, dv2);
        check(dv == 1'b1 && da == 1'b0, "R4 unicast rejected", {30'h0, dv, da}, 32'h2);

        // R5: gap in valid, extra bytes give one decision
        a  = 48'h01005E000001;
        ix = ref_index(a);
        clear_table();
        cfg(2'b10, 3'h0, 32'h0, ix);
        p0 = pulses;
        send(a, 3, 2'b00, 8'h0, 10, dv, da, dv2);
        repeat (2) @(negedge clk);
        check(dv == 1'b1 && da == 1'b1, "R5 gap keeps hash", {30'h0, dv, da}, 32'h3);
        check(pulses - p0 == 1, "R5 one decision per frame", 32'(pulses - p0), 32'd1);

        // R10: a new start byte restarts an incomplete address
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h33;
        @(negedge clk);
        rx_sof = 1'b0; rx_data = 8'h44;
        @(negedge clk);
        rx_data = 8'h55;
        p0 = pulses;
        send(a, 0, 2'b00, 8'h0, 0, dv, da, dv2);
        repeat (2) @(negedge clk);
        check(dv == 1'b1 && da == 1'b1, "R10 restart accepted", {30'h0, dv, da}, 32'h3);
        check(pulses - p0 == 1, "R10 one decision", 32'(pulses - p0), 32'd1);

        // R9: same-cycle set/clear applies from the next lookup
        clear_table();
        send(a, 0, 2'b10, ix, 0, dv, da, dv2);
        check(da == 1'b0, "R9 set same cycle not seen", {31'h0, da}, 32'h0);
        send(a, 0, 2'b00, 8'h0, 0, dv, da, dv2);
        check(da == 1'b1, "R9 set seen next frame", {31'h0, da}, 32'h1);
        send(a, 0, 2'b11, ix, 0, dv, da, dv2);
        check(da == 1'b1, "R9 clear same cycle not seen", {31'h0, da}, 32'h1);
        send(a, 0, 2'b00, 8'h0, 0, dv, da, dv2);
        check(da == 1'b0, "R9 clear seen next frame", {31'h0, da}, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule